// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches every pin of a GPIO bank made of several 8-bit ports and turns pin activity into interrupt requests. Each pin is given one of five trigger types: rising edge, falling edge, any edge, active-high level or active-low level. A detected event sets the pin's bit in a status vector. The bit stays set until software writes a 1 to the matching bit of the clear path.

The block ANDs the status vector with a per-pin enable vector and ORs the result into one bank interrupt line. Enable only gates this line. Status bits latch whether or not their pin is enabled.

Pin levels arrive already synchronized. Edges are found by comparing the current level with a copy delayed by one cycle. Register decoding lives in a separate register file, which drives the type, enable and clear inputs.

Top module: `gpio_evt_agg`

## Requirements
- R1: With type bits {any=0, edge=1, pol=1}, a 0-to-1 change on a pin sets its status bit at the next clock edge. A 1-to-0 change or a steady level sets nothing.
- R2: With type bits {any=0, edge=1, pol=0}, a 1-to-0 change sets the status bit and a 0-to-1 change does not.
- R3: With type bits {any=1, edge=1}, either change sets the status bit and a steady level does not. The pol bit is ignored.
- R4: With edge=0, the status bit is set on every clock edge where the pin was at the active level (high when pol=1, low when pol=0). A clear therefore lasts only once the pin is inactive.
- R5: A cycle with `clr_wr`=1 clears the status bits whose `clr_mask` bit is 1. Bits whose mask bit is 0 are unchanged, and `clr_mask` has no effect while `clr_wr`=0.
- R6: If an event on a pin and a clear of that pin happen in the same cycle, the status bit stays set.
- R7: `bank_irq` is 1 exactly when some pin has both its status bit and its `irq_en` bit at 1. Status latches regardless of `irq_en`.
- R8: Changing a pin's type bits does not clear that pin's status bit.
- R9: Reset clears all status bits and `bank_irq`. No edge is detected on the first clock edge after reset, whatever the pin levels are.
- R10: Pin p*8+b (port p, bit b) takes its pol, edge and any-edge bits from `trig_cfg` bits p*24+b, p*24+8+b and p*24+16+b. Its status, enable and clear bit is p*8+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | PORTS*PINS | Synchronized pin levels |
| trig_cfg | input | PORTS*PINS*3 | Per-port trigger type fields |
| irq_en | input | PORTS*PINS | Per-pin interrupt enable |
| clr_wr | input | 1 | Clear write strobe |
| clr_mask | input | PORTS*PINS | Write-1-to-clear mask |
| sts | output | PORTS*PINS | Latched event status |
| bank_irq | output | 1 | Aggregated bank interrupt |

## Verification
The bench builds the block with its default of four ports of eight pins. This makes the full 96-bit type field layout reachable, so pins in every port, and the top pin 31, are exercised. Each vector compares the whole 32-bit status word, so an event that lands on the wrong pin is caught as clearly as a missing one. It also reaches the collisions between a clear and a new event, and a clear against a level that is still active.

// File: rtl/gpio_evt_agg.sv
module gpio_evt_agg #(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORTS*PINS-1:0]   pin_lvl,
  input  logic [PORTS*PINS*3-1:0] trig_cfg,
  input  logic [PORTS*PINS-1:0]   irq_en,
  input  logic                    clr_wr,
  input  logic [PORTS*PINS-1:0]   clr_mask,
  output logic [PORTS*PINS-1:0]   sts,
  output logic                    bank_irq
);
  localparam int N = PORTS * PINS;

  logic [N-1:0] lvl_q;
  logic [N-1:0] evt;
  logic         primed;

  for (genvar i = 0; i < N; i++) begin : g_pin
    localparam int BASE = (i / PINS) * 3 * PINS + (i % PINS);
    logic pol, edg, any, rise, fall;
    assign pol  = trig_cfg[BASE];
    assign edg  = trig_cfg[BASE + PINS];
    assign any  = trig_cfg[BASE + 2*PINS];
    assign rise = primed &  pin_lvl[i] & ~lvl_q[i];
    assign fall = primed & ~pin_lvl[i] &  lvl_q[i];
    assign evt[i] = edg ? (any ? (rise | fall) : (pol ? rise : fall))
                        : (pol ? pin_lvl[i] : ~pin_lvl[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      primed <= 1'b0;
      sts    <= '0;
    end else begin
      lvl_q  <= pin_lvl;
      primed <= 1'b1;
      sts    <= (sts & ~(clr_wr ? clr_mask : '0)) | evt;
    end
  end

  assign bank_irq = |(sts & irq_en);
endmodule

// File: rtl/gpio_evt_agg_chk.sv
module gpio_evt_agg_chk #(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PORTS*PINS-1:0]   pin_lvl,
  input logic [PORTS*PINS*3-1:0] trig_cfg,
  input logic [PORTS*PINS-1:0]   irq_en,
  input logic                    clr_wr,
  input logic [PORTS*PINS-1:0]   clr_mask,
  input logic [PORTS*PINS-1:0]   sts,
  input logic                    bank_irq
);
  localparam int N = PORTS * PINS;

  logic [N-1:0] wipe, hi_lvl;
  logic         armed;

  assign wipe = clr_wr ? clr_mask : '0;
  for (genvar i = 0; i < N; i++) begin : g_m
    localparam int BASE = (i / PINS) * 3 * PINS + (i % PINS);
    assign hi_lvl[i] = trig_cfg[BASE] & ~trig_cfg[BASE + PINS];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts) & ~$past(wipe)) & ~sts) == '0));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(hi_lvl & pin_lvl) & ~sts) == '0));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !bank_irq);

  assert_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sts & irq_en) != 0) |-> bank_irq);
endmodule

bind gpio_evt_agg gpio_evt_agg_chk #(.PORTS(PORTS), .PINS(PINS)) u_chk (.*);

// File: tb/gpio_evt_agg_bench.sv
`timescale 1ns/1ps
module gpio_evt_agg_bench;
  localparam int N = 32;
  localparam logic [2:0] M_RISE = 3'b011, M_FALL = 3'b010, M_ANY = 3'b110,
                         M_HIGH = 3'b001, M_LOW = 3'b000;
  localparam logic [9:0] VEC [12] = '{
    {5'd0,  M_RISE, 1'b0, 1'b1}, {5'd9,  M_RISE, 1'b1, 1'b0},
    {5'd17, M_FALL, 1'b1, 1'b0}, {5'd26, M_FALL, 1'b0, 1'b1},
    {5'd31, M_ANY,  1'b0, 1'b1}, {5'd5,  M_ANY,  1'b1, 1'b0},
    {5'd12, M_ANY,  1'b1, 1'b1}, {5'd20, M_HIGH, 1'b0, 1'b1},
    {5'd27, M_LOW,  1'b1, 1'b0}, {5'd2,  M_HIGH, 1'b0, 1'b0},
    {5'd14, M_LOW,  1'b1, 1'b1}, {5'd23, M_RISE, 1'b1, 1'b1}};

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_lvl = '0, irq_en = '0, clr_mask = '0, sts;
  logic [3*N-1:0] trig_cfg = '0;
  logic clr_wr = 0, bank_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_evt_agg u_gpio_evt_agg (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
    .trig_cfg(trig_cfg), .irq_en(irq_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .sts(sts), .bank_irq(bank_irq));

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(int pin, logic [2:0] m);
    int base = (pin / 8) * 24 + pin % 8;
    trig_cfg[base]      = m[0];
    trig_cfg[base + 8]  = m[1];
    trig_cfg[base + 16] = m[2];
  endtask

  task automatic clear(logic [N-1:0] m);
    clr_wr = 1; clr_mask = m; step(); clr_wr = 0; clr_mask = '0;
  endtask

  function automatic logic expect_bit(logic [2:0] m, logic b, logic a);
    if (m[1]) return m[2] ? (a != b) : (m[0] ? (!b && a) : (b && !a));
    return m[0] ? (b | a) : (!b | !a);
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) trig_cfg[p*24 +: 24] = 24'h00FFFF;
    pin_lvl = '1;
    repeat (3) @(negedge clk);
    chk("R9 reset status", sts, '0);
    chk("R9 reset irq", {31'd0, bank_irq}, '0);
    rst_n = 1;
    step();
    chk("R9 no edge after reset", sts, '0);
    step();
    chk("R1 steady high no event", sts, '0);
    for (int p = 0; p < 4; p++) trig_cfg[p*24 +: 24] = 24'h00FF00;
    pin_lvl = '0;
    step();
    chk("R2 R10 falling all pins", sts, '1);
    clear('1);
    chk("R5 full clear", sts, '0);

    for (int r = 0; r < 12; r++) begin
      int pin = int'(VEC[r][9:5]);
      logic [2:0] m = VEC[r][4:2];
      logic b = VEC[r][1], a = VEC[r][0];
      set_mode(pin, m);
      pin_lvl[pin] = b;
      step(); step();
      clear('1);
      pin_lvl[pin] = a;
      step();
      chk($sformatf("R1 R2 R3 R4 R10 vector %0d", r), sts,
          {31'd0, expect_bit(m, b, a)} << pin);
      set_mode(pin, M_FALL);
      pin_lvl[pin] = 1'b0;
      step();
      clear('1);
    end
    chk("R5 idle after vectors", sts, '0);

    pin_lvl[3] = 1; pin_lvl[12] = 1; step();
    pin_lvl[3] = 0; pin_lvl[12] = 0; step();
    chk("R2 two falling edges", sts, (32'd1 << 3) | (32'd1 << 12));
    clr_mask = '1; step(); clr_mask = '0;
    chk("R5 mask without strobe", sts, (32'd1 << 3) | (32'd1 << 12));
    clear('0);
    chk("R5 zero mask", sts, (32'd1 << 3) | (32'd1 << 12));
    clear(32'd1 << 3);
    chk("R5 selective clear", sts, 32'd1 << 12);

    pin_lvl[12] = 1; step();
    pin_lvl[12] = 0; clear(32'd1 << 12);
    chk("R6 event beats clear", sts, 32'd1 << 12);

    set_mode(12, M_HIGH); step();
    chk("R8 type change keeps status", sts, 32'd1 << 12);
    set_mode(12, M_FALL);

    chk("R7 no enable no irq", {31'd0, bank_irq}, '0);
    irq_en = 32'd1 << 30; #1;
    chk("R7 enabled but idle pin", {31'd0, bank_irq}, '0);
    irq_en = 32'd1 << 12; #1;
    chk("R7 pending irq", {31'd0, bank_irq}, 32'd1);
    @(negedge clk);
    clear(32'd1 << 12);
    chk("R7 irq drops after clear", {31'd0, bank_irq}, '0);
    irq_en = '0;
    pin_lvl[30] = 1; step(); pin_lvl[30] = 0; step();
    chk("R7 latch while disabled", sts, 32'd1 << 30);
    irq_en = 32'd1 << 30; #1;
    chk("R7 irq on late enable", {31'd0, bank_irq}, 32'd1);
    @(negedge clk);
    irq_en = '0;
    clear('1);

    set_mode(7, M_HIGH); pin_lvl[7] = 1; step();
    clear(32'd1 << 7);
    chk("R4 level reasserts after clear", sts, 32'd1 << 7);
    pin_lvl[7] = 0; clear(32'd1 << 7);
    chk("R4 clear sticks when inactive", sts, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule